// File: doc/BRIEF.md
# Frame-level erasure-code encoder for a lossy link

This block sits on the transmit side of a link known to drop or corrupt frames. Frames arrive one byte per beat on a valid/ready stream with start and end flags, together with a traffic-class number. A small class table, written by management, gives each class a data count k and a redundancy count h. A class with k set to zero is a pass-through class: its frames leave exactly as they came.

For a coding class, every frame is forwarded as it arrives with a two-byte label in front: a block sequence number and the frame's slot within its block. While the frame flows through, its bytes are folded into h running parity rows, one byte of state per byte position per row, using Galois-field weights so that row 0 is a plain XOR and each further row is an independent combination. When k frames have been collected, or earlier when a frame of another class shows up, the block is closed and h parity frames are sent. Each holds its own label, the count of data frames actually in the block, the length of every data frame, and one parity byte per position up to the longest frame of the block.

Top module: `fec_enc`

## Requirements
- R1: After reset, out_valid and in_ready are low, no block is open, the next block sequence number is 0 and every class reads as pass-through (k = 0).
- R2: A frame of a coding class leaves as two label bytes followed by its payload unchanged: first the block sequence number, then the byte {3'b000, slot[4:0]} where slot counts 0, 1, ... within the block; out_sof marks the first label byte and out_eof the last payload byte.
- R3: A frame of a class whose k is 0 leaves byte for byte with its own start and end flags, no label, and is not counted in any block.
- R4: Once a block closes and its h is nonzero, h parity frames follow in order j = 0 .. h-1, each made of: sequence number, byte 0x20 | j, the data frame count n, then n 16-bit big-endian frame lengths in slot order, then the parity bytes.
- R5: Parity byte j at position p is the GF(2^8) sum (polynomial 0x11D, alpha = 2) over slots i of alpha^(j*i) times byte p of frame i, frames shorter than p+1 bytes counting as zero; each parity frame carries as many parity bytes as the longest frame of its block.
- R6: A block closes after k frames, or early when a coding or pass-through frame of a different class arrives while it is open, in which case its parity is sent with the smaller count before the new frame is taken; the sequence number advances by one per closed block and wraps from 255 to 0.
- R7: in_ready is low while label or parity bytes are being produced; when out_ready is low, a presented output byte and its flags stay unchanged until taken.
- R8: A class-table write sets k and h for one class; the values in force for a block are those read when its first frame arrives, so a later write affects only later blocks.
- R9: Payload bytes are not stored before forwarding: a byte taken on the input appears on the output registers on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Class-table write strobe |
| cfg_cls | input | CW | Class being written |
| cfg_k | input | KW | Data frames per block (0 = pass-through) |
| cfg_h | input | HW | Parity frames per block |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_cls | input | CW | Traffic class of the frame, held for the whole frame |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |

## Verification
The hardest states to reach are an early close, where a frame of another class must arrive while a block still holds fewer than k frames, and a sequence-number wrap, which needs 256 closed blocks. The stimulus drives both on purpose: a class switch after a partial block, a pass-through frame interrupting a block, a long run of one-frame blocks, and a table rewrite in the middle of a block. Random traffic over randomly configured classes with random frame lengths, input gaps and output stalls then mixes early closes, short frames under long ones and back-pressure during parity output.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TAG0, S_TAG1, S_DATA, S_PHDR, S_PLEN, S_PPAR
  } fec_st_t;

  // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x^2+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1D : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_alpha_pow(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < n; i++) r = gf_mul(r, 8'h02);
    return r;
  endfunction

endpackage

// File: rtl/fec_cfg_table.sv
module fec_cfg_table #(
  parameter int NCLASS = 4,
  parameter int CW     = 2,
  parameter int KW     = 5,
  parameter int HW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wr_cls,
  input  logic [KW-1:0] wr_k,
  input  logic [HW-1:0] wr_h,
  input  logic [CW-1:0] rd_cls,
  output logic [KW-1:0] rd_k,
  output logic [HW-1:0] rd_h
);
  logic [KW-1:0] k_tab [NCLASS];
  logic [HW-1:0] h_tab [NCLASS];

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst) begin
        k_tab[c] <= '0;
        h_tab[c] <= '0;
      end else if (we && (wr_cls == CW'(c))) begin
        k_tab[c] <= wr_k;
        h_tab[c] <= wr_h;
      end
    end
  end

  assign rd_k = k_tab[rd_cls];
  assign rd_h = h_tab[rd_cls];
endmodule

// File: rtl/fec_parity_mem.sv
module fec_parity_mem #(
  parameter int MAX_H   = 10,
  parameter int MAX_LEN = 256,
  parameter int AW      = 8,
  parameter int JW      = 4
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_byte,
  input  logic                  old_zero,
  input  logic [MAX_H-1:0][7:0] coef,
  input  logic [JW-1:0]         rd_lane,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_byte
);
  import fec_pkg::*;

  logic [7:0] lane_rd [MAX_H];

  for (genvar g = 0; g < MAX_H; g++) begin : g_lane
    logic [7:0] row [MAX_LEN];
    logic [7:0] prev;
    assign prev = old_zero ? 8'h00 : row[wr_addr];
    always_ff @(posedge clk) begin
      if (wr_en) row[wr_addr] <= prev ^ gf_mul(coef[g], wr_byte);
    end
    assign lane_rd[g] = row[rd_addr];
  end

  assign rd_byte = lane_rd[rd_lane];
endmodule

// File: rtl/fec_enc.sv
module fec_enc #(
  parameter int NCLASS  = 4,
  parameter int MAX_K   = 25,
  parameter int MAX_H   = 10,
  parameter int MAX_LEN = 256,
  localparam int CW = (NCLASS > 1) ? $clog2(NCLASS) : 1,
  localparam int KW = $clog2(MAX_K + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_cls,
  input  logic [KW-1:0] cfg_k,
  input  logic [HW-1:0] cfg_h,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [CW-1:0] in_cls,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_sof,
  output logic          out_eof
);
  import fec_pkg::*;

  localparam int AW = $clog2(MAX_LEN);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int JW = (MAX_H > 1) ? $clog2(MAX_H) : 1;
  localparam int EW = (LW > KW + 1) ? LW : KW + 1;
  localparam logic [LW-1:0] ONE_L = 1;
  localparam logic [KW-1:0] ONE_K = 1;
  localparam logic [HW-1:0] ONE_H = 1;
  localparam logic [JW-1:0] ONE_J = 1;
  localparam logic [EW-1:0] ONE_E = 1;
  localparam logic [EW-1:0] TWO_E = 2;

  fec_st_t       st;
  logic [CW-1:0] open_cls;
  logic [KW-1:0] bk, cnt, tk;
  logic [HW-1:0] bh, th;
  logic [7:0]    seq;
  logic [LW-1:0] maxl, pos;
  logic [EW-1:0] ecnt;
  logic [JW-1:0] pj;
  logic          byp;
  logic [LW-1:0] lens [MAX_K];
  logic [MAX_H-1:0][7:0] coef;
  logic [7:0]    par_rd;

  logic adv, acc, cls_switch, start_frame;
  logic [KW-1:0] nxt_cnt;
  logic [KW-1:0] lidx;
  logic [15:0]   lval;

  assign adv         = !out_valid || out_ready;
  assign in_ready    = (st == S_DATA) && adv;
  assign acc         = in_valid && in_ready;
  assign cls_switch  = (cnt != '0) && (in_cls != open_cls);
  assign start_frame = (st == S_IDLE) && in_valid && in_sof && !cls_switch && (tk != '0);
  assign nxt_cnt     = cnt + ONE_K;
  assign lidx        = KW'(ecnt >> 1);
  assign lval        = 16'(lens[lidx]);

  fec_cfg_table #(.NCLASS(NCLASS), .CW(CW), .KW(KW), .HW(HW)) u_tab (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_cls(cfg_cls), .wr_k(cfg_k), .wr_h(cfg_h),
    .rd_cls(in_cls), .rd_k(tk), .rd_h(th)
  );

  fec_parity_mem #(.MAX_H(MAX_H), .MAX_LEN(MAX_LEN), .AW(AW), .JW(JW)) u_par (
    .clk(clk), .wr_en(acc && !byp), .wr_addr(AW'(pos)), .wr_byte(in_data),
    .old_zero(pos >= maxl), .coef(coef), .rd_lane(pj), .rd_addr(AW'(ecnt)),
    .rd_byte(par_rd)
  );

  // per-row weight alpha^(j*slot), advanced by alpha^j at each new frame
  for (genvar g = 0; g < MAX_H; g++) begin : g_coef
    localparam logic [7:0] STEP = gf_alpha_pow(g);
    always_ff @(posedge clk) begin
      if (rst) coef[g] <= 8'h01;
      else if (start_frame) coef[g] <= (cnt == '0) ? 8'h01 : gf_mul(coef[g], STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !byp && in_eof) lens[cnt] <= pos + ONE_L;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
      cnt <= '0;     seq <= '0;         maxl <= '0;     pos <= '0;       ecnt <= '0;
      pj <= '0;      byp <= 1'b0;       open_cls <= '0; bk <= '0;        bh <= '0;
    end else begin
      if (adv) out_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (in_valid && in_sof) begin
          if (cls_switch) begin
            if (bh == '0) begin seq <= seq + 8'd1; cnt <= '0; end
            else begin st <= S_PHDR; ecnt <= '0; pj <= '0; end
          end else if (tk == '0) begin
            byp <= 1'b1; st <= S_DATA;
          end else begin
            byp <= 1'b0; pos <= '0; st <= S_TAG0;
            if (cnt == '0) begin
              open_cls <= in_cls; bk <= tk; bh <= th; maxl <= '0;
            end
          end
        end
        S_TAG0: if (adv) begin
          out_valid <= 1'b1; out_data <= seq; out_sof <= 1'b1; out_eof <= 1'b0; st <= S_TAG1;
        end
        S_TAG1: if (adv) begin
          out_valid <= 1'b1; out_data <= 8'(cnt); out_sof <= 1'b0; out_eof <= 1'b0; st <= S_DATA;
        end
        S_DATA: if (acc) begin
          out_valid <= 1'b1; out_data <= in_data; out_sof <= byp && in_sof; out_eof <= in_eof;
          pos <= pos + ONE_L;
          if (in_eof) begin
            if (byp) st <= S_IDLE;
            else begin
              if (pos + ONE_L > maxl) maxl <= pos + ONE_L;
              cnt <= nxt_cnt;
              st  <= S_IDLE;
              if (nxt_cnt == bk) begin
                if (bh == '0) begin seq <= seq + 8'd1; cnt <= '0; end
                else begin st <= S_PHDR; ecnt <= '0; pj <= '0; end
              end
            end
          end
        end
        S_PHDR: if (adv) begin
          out_valid <= 1'b1; out_sof <= (ecnt == '0); out_eof <= 1'b0;
          if (ecnt == '0)        out_data <= seq;
          else if (ecnt == ONE_E) out_data <= 8'h20 | 8'(pj);
          else                   out_data <= 8'(cnt);
          if (ecnt == TWO_E) begin ecnt <= '0; st <= S_PLEN; end
          else ecnt <= ecnt + ONE_E;
        end
        S_PLEN: if (adv) begin
          out_valid <= 1'b1; out_sof <= 1'b0; out_eof <= 1'b0;
          out_data  <= ecnt[0] ? lval[7:0] : lval[15:8];
          if (ecnt + ONE_E == EW'({cnt, 1'b0})) begin ecnt <= '0; st <= S_PPAR; end
          else ecnt <= ecnt + ONE_E;
        end
        S_PPAR: if (adv) begin
          out_valid <= 1'b1; out_sof <= 1'b0; out_data <= par_rd;
          out_eof   <= (ecnt + ONE_E == EW'(maxl));
          if (ecnt + ONE_E == EW'(maxl)) begin
            ecnt <= '0;
            if (HW'(pj) + ONE_H == bh) begin
              seq <= seq + 8'd1; cnt <= '0; st <= S_IDLE;
            end else begin
              pj <= pj + ONE_J; st <= S_PHDR;
            end
          end else ecnt <= ecnt + ONE_E;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fec_enc_chk.sv
module fec_enc_chk #(
  parameter int MAX_K = 25,
  parameter int KW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_sof,
  input logic              out_eof,
  input fec_pkg::fec_st_t  st,
  input logic [KW-1:0]     blk_cnt
);
  import fec_pkg::*;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));

  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  a_r7_no_input_while_generating: assert property (@(posedge clk) disable iff (rst)
    (st == S_TAG0 || st == S_TAG1 || st == S_PHDR || st == S_PLEN || st == S_PPAR) |-> !in_ready);

  a_r9_cut_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r6_block_bound: assert property (@(posedge clk) disable iff (rst)
    (32'(blk_cnt) < MAX_K) || (st == S_PHDR || st == S_PLEN || st == S_PPAR));
endmodule

bind fec_enc fec_enc_chk #(.MAX_K(MAX_K), .KW(KW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .st(st), .blk_cnt(cnt)
);

// File: tb/sim_fec_enc.sv
module sim_fec_enc;
  localparam int CLK_PERIOD = 10;
  localparam int NCL = 4;
  localparam int MAXL = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_cls = '0;
  logic [4:0] cfg_k = '0;
  logic [3:0] cfg_h = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_cls = '0;
  logic in_ready, out_valid, out_sof, out_eof;
  logic out_ready = 1'b1;
  logic [7:0] out_data;

  fec_enc u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cls(cfg_cls), .cfg_k(cfg_k), .cfg_h(cfg_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_cls(in_cls), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int rdy_pct = 100, gap_pct = 0;
  bit chk9_en = 0;
  logic took = 1'b0;
  logic [7:0] took_byte = '0;
  logic [9:0] exp_q [$];
  logic [9:0] got_q [$];

  // model state
  int cfgk [NCL], cfgh [NCL];
  int ocls, ocnt, oseq, okk, ohh, omax;
  int lens [32];
  logic [7:0] par [10][MAXL];
  logic [7:0] fb [MAXL];

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] apow(input int n);
    logic [7:0] r = 1;
    for (int i = 0; i < n % 255; i++) r = gmul(r, 8'h02);
    return r;
  endfunction

  function automatic void push(input int d, input bit s, input bit e);
    exp_q.push_back({s, e, 8'(d)});
  endfunction

  function automatic void model_close();
    for (int j = 0; j < ohh; j++) begin
      push(oseq, 1, 0); push(8'h20 | j, 0, 0); push(ocnt, 0, 0);
      for (int i = 0; i < ocnt; i++) begin push(lens[i] >> 8, 0, 0); push(lens[i] & 255, 0, 0); end
      for (int p = 0; p < omax; p++) push(par[j][p], 0, p == omax - 1);
    end
    oseq = (oseq + 1) % 256;
    ocnt = 0;
  endfunction

  function automatic void model_frame(input int cls, input int n);
    if (ocnt > 0 && cls != ocls) model_close();
    if (cfgk[cls] == 0) begin
      for (int p = 0; p < n; p++) push(fb[p], p == 0, p == n - 1);
      return;
    end
    if (ocnt == 0) begin
      ocls = cls; okk = cfgk[cls]; ohh = cfgh[cls]; omax = 0;
      for (int j = 0; j < 10; j++) for (int p = 0; p < MAXL; p++) par[j][p] = 0;
    end
    push(oseq, 1, 0); push(ocnt, 0, 0);
    for (int p = 0; p < n; p++) begin
      push(fb[p], 0, p == n - 1);
      for (int j = 0; j < ohh; j++) par[j][p] ^= gmul(apow(j * ocnt), fb[p]);
    end
    lens[ocnt] = n;
    if (n > omax) omax = n;
    ocnt++;
    if (ocnt == okk) model_close();
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    took <= in_valid && in_ready;
    took_byte <= in_data;
  end

  always @(posedge clk) begin
    #1 out_ready = ($urandom % 100) < rdy_pct;
  end

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) got_q.push_back({out_sof, out_eof, out_data});
    if (!rst && chk9_en && took) begin
      checks++;
      if (!(out_valid && out_data == took_byte)) begin
        errors++;
        $display("FAIL R9: cut-through byte got valid=%0b data=%02h expected valid=1 data=%02h",
                 out_valid, out_data, took_byte);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: cycle %0d expected completion before 190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); got_q.delete();
    for (int c = 0; c < NCL; c++) begin cfgk[c] = 0; cfgh[c] = 0; end
    ocnt = 0; oseq = 0; ocls = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset out_valid=%0b in_ready=%0b expected 0 0", out_valid, in_ready);
    end
  endtask

  task automatic set_cfg(input int cls, input int k, input int h);
    cfg_we = 1'b1; cfg_cls = 2'(cls); cfg_k = 5'(k); cfg_h = 4'(h);
    @(negedge clk);
    cfg_we = 1'b0;
    cfgk[cls] = k; cfgh[cls] = h;
  endtask

  task automatic send_frame(input int cls, input int n);
    for (int p = 0; p < n; p++) fb[p] = 8'($urandom);
    model_frame(cls, n);
    for (int p = 0; p < n; p++) begin
      if (($urandom % 100) < gap_pct) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_data = fb[p]; in_sof = (p == 0); in_eof = (p == n - 1); in_cls = 2'(cls);
      @(negedge clk);
      while (!took) @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic compare(input string rq);
    int t = 0;
    int bad = -1;
    while (got_q.size() < exp_q.size() && t < 40000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s: output byte count %0d expected %0d", rq, got_q.size(), exp_q.size());
    end
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: byte %0d got sof/eof/data %03h expected %03h", rq, bad, got_q[bad], exp_q[bad]);
    end
  endtask

  initial begin
    void'($urandom(32'd20241));

    // R2 R4 R5 R9: full block k=5 h=5, free-flowing output
    do_reset();
    set_cfg(0, 5, 5);
    chk9_en = 1;
    for (int f = 0; f < 5; f++) send_frame(0, 1 + $urandom % 40);
    compare("R2/R4/R5 full block");
    chk9_en = 0;

    // R3 R9: pass-through class only
    do_reset();
    set_cfg(1, 0, 3);
    chk9_en = 1;
    send_frame(1, 1); send_frame(1, 17); send_frame(1, 3);
    compare("R3 pass-through");
    chk9_en = 0;

    // R6: early close on class switch, then a 25-frame block, then bypass interrupt
    do_reset();
    rdy_pct = 70; gap_pct = 20;
    set_cfg(0, 10, 3); set_cfg(2, 25, 1); set_cfg(1, 0, 0);
    for (int f = 0; f < 4; f++) send_frame(0, 1 + $urandom % 20);
    for (int f = 0; f < 25; f++) send_frame(2, 1 + $urandom % 12);
    send_frame(0, 5); send_frame(0, 2); send_frame(1, 6); send_frame(0, 4);
    send_frame(2, 3);
    compare("R6 early close");

    // R8: table rewrite mid-block affects only the next block
    do_reset();
    set_cfg(0, 3, 2);
    send_frame(0, 8);
    set_cfg(0, 2, 1);
    send_frame(0, 3); send_frame(0, 9);
    send_frame(0, 4); send_frame(0, 4);
    compare("R8 table latch");

    // R5 R7: longest and shortest frames, ten parity rows, heavy stalls
    do_reset();
    rdy_pct = 35; gap_pct = 30;
    set_cfg(3, 2, 10);
    send_frame(3, MAXL); send_frame(3, 1);
    send_frame(3, 1); send_frame(3, 2);
    compare("R5/R7 length extremes");

    // R6: sequence wrap over 258 one-frame blocks
    do_reset();
    rdy_pct = 100; gap_pct = 0;
    set_cfg(3, 1, 1);
    for (int f = 0; f < 258; f++) send_frame(3, 1);
    compare("R6 sequence wrap");

    // random mix over all classes
    for (int r = 0; r < 3; r++) begin
      do_reset();
      rdy_pct = 50 + $urandom % 51; gap_pct = $urandom % 30;
      for (int c = 0; c < NCL; c++) set_cfg(c, ($urandom % 4 == 0) ? 0 : 1 + $urandom % 25, 1 + $urandom % 10);
      for (int f = 0; f < 40; f++) begin
        int c = $urandom % NCL;
        if ($urandom % 3 != 0) c = r % NCL;
        send_frame(c, 1 + $urandom % 60);
      end
      compare("R2/R4/R5/R6/R7 random mix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule